// File: doc/BRIEF.md
# Toeplitz Correlation Estimator

This block sits in front of the tap-weight solver of a chip-rate equalizer. It takes a stream of complex matched-filter chip samples and the pilot scrambling code, one chip at a time. From them it estimates the statistics the solver needs. Every 256 reference chips it closes one block. For that block it forms N lag sums of the sample autocorrelation and N sums of the correlation between the samples and the known pilot reference.

The solver treats the autocorrelation matrix as Hermitian Toeplitz. Every diagonal therefore shares one value, and the block only delivers the first row: lags 0 to N-1. The pilot reference for chip i is (1+j) times the complex scrambling chip. That product reduces to sign selections, so it needs no multiplier. Each block result is averaged with the three blocks before it. The averages are then presented on wide output buses together with a one-cycle strobe, and they stay there until the next block closes.

A delay line of N-1 samples supplies the look-ahead samples for the lag products. Because of it, consecutive blocks follow one another without a gap. Only the first N-1 chips after reset are spent filling the line.

Top module: `toeplitz_corr_est`

## Requirements
- R1: While rst_ni is low, and from then until the first block completes, corr_valid_o is 0 and all four correlation buses are zero.
- R2: Let i be the reference index of a block, running 0..255, and x[] the accepted chip sequence. Chip x[i+k] is counted from the first accepted chip after reset, with an offset of N-1 for fill. Lag k of the autocorrelation block sum is the sum of x[i+k]·conj(x[i]).
- R3: Let c[i] be the scrambling chip, with each code bit meaning 0 = +1 and 1 = -1 and given as real and imaginary parts. Lag k of the cross block sum is the sum of x[i+k]·(1+j)·c[i], where c[i] is taken alongside x[i].
- R4: Each output is the floor of a quarter of the sum of the current block sum and the three previous block sums. Block sums from before reset count as zero.
- R5: corr_valid_o pulses for exactly one cycle. It rises in the cycle after the clock edge that accepts chip number 256·(b+1)+N-1 since reset, for block b = 0, 1, 2, … Pulses are therefore at least 256 accepted chips apart.
- R6: Between pulses, all four output buses hold their values.
- R7: Cycles with chip_valid_i low change nothing. Their sample and code values are ignored, so idle cycles inside a block leave the results equal to those of a gap-free stream.
- R8: At every pulse, the lag-0 autocorrelation has an imaginary part of zero and a non-negative real part.
- R9: Lag k occupies bits [k·AW +: AW] of each bus, as a two's-complement value with AW = 2·XW+9.
- R10: A reset in the middle of a block clears the fill state, the block position and the averaging history. The next block after release yields its own sum divided by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_valid_i | input | 1 | Chip sample and code are present this cycle |
| chip_re_i | input | XW | Sample, real part, signed |
| chip_im_i | input | XW | Sample, imaginary part, signed |
| code_re_i | input | 1 | Scrambling chip, real sign (0 = +1, 1 = -1) |
| code_im_i | input | 1 | Scrambling chip, imaginary sign (0 = +1, 1 = -1) |
| corr_valid_o | output | 1 | One-cycle strobe: new averages on the buses |
| auto_re_o | output | N·AW | Averaged autocorrelation lags, real parts |
| auto_im_o | output | N·AW | Averaged autocorrelation lags, imaginary parts |
| xcorr_re_o | output | N·AW | Averaged pilot cross-correlation, real parts |
| xcorr_im_o | output | N·AW | Averaged pilot cross-correlation, imaginary parts |

## Verification
The assertions assume that reset is asserted from time zero and that chip_valid_i is never X once reset is released. They also assume that the strobe can only follow a cycle in which a chip was accepted. The hold and single-pulse properties depend on a block lasting 256 accepted chips. The stimulus keeps to this: inputs are driven only on falling edges, and the strobe is never expected more often than that. Sample values stay inside the signed XW-bit range, including the most negative code, and the largest block sums still fit in AW bits.

// File: rtl/tce_pkg.sv
package tce_pkg;
  localparam int BLK_LEN    = 256;
  localparam int BLK_BITS   = 8;
  localparam int HIST_DEPTH = 4;
  localparam int HIST_SHIFT = 2;

  // half of (1+j)*c, each part in {-1,0,+1}
  typedef struct packed {
    logic signed [1:0] re;
    logic signed [1:0] im;
  } pilot_t;

  function automatic pilot_t pilot_half(input logic c_re, input logic c_im);
    pilot_t p;
    unique case ({c_re, c_im})
      2'b00:   begin p.re = 2'sb00; p.im = 2'sb01; end
      2'b01:   begin p.re = 2'sb01; p.im = 2'sb00; end
      2'b10:   begin p.re = 2'sb11; p.im = 2'sb00; end
      default: begin p.re = 2'sb00; p.im = 2'sb11; end
    endcase
    return p;
  endfunction
endpackage

// File: rtl/tce_delay.sv
module tce_delay #(
  parameter int N  = 7,
  parameter int XW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic signed [XW-1:0] x_re_i,
  input  logic signed [XW-1:0] x_im_i,
  input  logic                 c_re_i,
  input  logic                 c_im_i,
  output logic signed [XW-1:0] tap_re_o [N],
  output logic signed [XW-1:0] tap_im_o [N],
  output logic                 c_re_o,
  output logic                 c_im_o
);
  localparam int DL = N - 1;

  logic signed [XW-1:0] dl_re [DL];
  logic signed [XW-1:0] dl_im [DL];
  logic                 cd_re [DL];
  logic                 cd_im [DL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < DL; j++) begin
        dl_re[j] <= '0;
        dl_im[j] <= '0;
        cd_re[j] <= 1'b0;
        cd_im[j] <= 1'b0;
      end
    end else if (shift_i) begin
      dl_re[0] <= x_re_i;
      dl_im[0] <= x_im_i;
      cd_re[0] <= c_re_i;
      cd_im[0] <= c_im_i;
      for (int j = 1; j < DL; j++) begin
        dl_re[j] <= dl_re[j-1];
        dl_im[j] <= dl_im[j-1];
        cd_re[j] <= cd_re[j-1];
        cd_im[j] <= cd_im[j-1];
      end
    end
  end

  // tap k holds the sample k chips older than the input
  assign tap_re_o[0] = x_re_i;
  assign tap_im_o[0] = x_im_i;
  for (genvar k = 1; k < N; k++) begin : g_tap
    assign tap_re_o[k] = dl_re[k-1];
    assign tap_im_o[k] = dl_im[k-1];
  end

  assign c_re_o = cd_re[DL-1];
  assign c_im_o = cd_im[DL-1];
endmodule

// File: rtl/tce_lane.sv
module tce_lane
  import tce_pkg::*;
#(
  parameter int XW = 8,
  parameter int AW = 2*XW + 1 + BLK_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 act_i,
  input  logic                 first_i,
  input  logic signed [XW-1:0] lead_re_i,
  input  logic signed [XW-1:0] lead_im_i,
  input  logic signed [XW-1:0] ref_re_i,
  input  logic signed [XW-1:0] ref_im_i,
  input  pilot_t               pil_i,
  output logic signed [AW-1:0] ac_re_o,
  output logic signed [AW-1:0] ac_im_o,
  output logic signed [AW-1:0] xc_re_o,
  output logic signed [AW-1:0] xc_im_o
);
  localparam int MW = 2*XW;

  function automatic logic signed [AW-1:0] ext_m(input logic signed [MW-1:0] v);
    return {{(AW-MW){v[MW-1]}}, v};
  endfunction

  function automatic logic signed [AW-1:0] ext_x(input logic signed [XW-1:0] v);
    return {{(AW-XW){v[XW-1]}}, v};
  endfunction

  function automatic logic signed [AW-1:0] pick(input logic signed [AW-1:0] v,
                                                input logic signed [1:0] s);
    unique case (s)
      2'sb01:  return v;
      2'sb11:  return -v;
      default: return '0;
    endcase
  endfunction

  logic signed [MW-1:0] m_rr, m_ii, m_ir, m_ri;
  logic signed [AW-1:0] a_ext, b_ext;
  logic signed [AW-1:0] ac_p_re, ac_p_im, xc_p_re, xc_p_im;
  logic signed [AW-1:0] ac_q_re, ac_q_im, xc_q_re, xc_q_im;

  // lead * conj(ref)
  assign m_rr    = lead_re_i * ref_re_i;
  assign m_ii    = lead_im_i * ref_im_i;
  assign m_ir    = lead_im_i * ref_re_i;
  assign m_ri    = lead_re_i * ref_im_i;
  assign ac_p_re = ext_m(m_rr) + ext_m(m_ii);
  assign ac_p_im = ext_m(m_ir) - ext_m(m_ri);

  // lead * 2*pil, no multiplier
  assign a_ext   = ext_x(lead_re_i);
  assign b_ext   = ext_x(lead_im_i);
  assign xc_p_re = (pick(a_ext, pil_i.re) - pick(b_ext, pil_i.im)) <<< 1;
  assign xc_p_im = (pick(a_ext, pil_i.im) + pick(b_ext, pil_i.re)) <<< 1;

  assign ac_re_o = first_i ? ac_p_re : ac_q_re + ac_p_re;
  assign ac_im_o = first_i ? ac_p_im : ac_q_im + ac_p_im;
  assign xc_re_o = first_i ? xc_p_re : xc_q_re + xc_p_re;
  assign xc_im_o = first_i ? xc_p_im : xc_q_im + xc_p_im;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q_re <= '0;
      ac_q_im <= '0;
      xc_q_re <= '0;
      xc_q_im <= '0;
    end else if (act_i) begin
      ac_q_re <= ac_re_o;
      ac_q_im <= ac_im_o;
      xc_q_re <= xc_re_o;
      xc_q_im <= xc_im_o;
    end
  end
endmodule

// File: rtl/tce_smooth.sv
module tce_smooth
  import tce_pkg::*;
#(
  parameter int AW = 25
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_i,
  input  logic signed [AW-1:0] sum_i,
  output logic signed [AW-1:0] avg_o
);
  localparam int RW = AW + HIST_SHIFT;

  logic signed [AW-1:0] hist [HIST_DEPTH];
  logic signed [RW-1:0] run_q, run_d;

  assign run_d = run_q + RW'(sum_i) - RW'(hist[HIST_DEPTH-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < HIST_DEPTH; j++) hist[j] <= '0;
      run_q <= '0;
      avg_o <= '0;
    end else if (push_i) begin
      hist[0] <= sum_i;
      for (int j = 1; j < HIST_DEPTH; j++) hist[j] <= hist[j-1];
      run_q <= run_d;
      avg_o <= run_d[RW-1:HIST_SHIFT];
    end
  end
endmodule

// File: rtl/toeplitz_corr_est.sv
module toeplitz_corr_est
  import tce_pkg::*;
#(
  parameter  int N  = 7,
  parameter  int XW = 8,
  localparam int AW = 2*XW + 1 + BLK_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 chip_valid_i,
  input  logic signed [XW-1:0] chip_re_i,
  input  logic signed [XW-1:0] chip_im_i,
  input  logic                 code_re_i,
  input  logic                 code_im_i,
  output logic                 corr_valid_o,
  output logic [N*AW-1:0]      auto_re_o,
  output logic [N*AW-1:0]      auto_im_o,
  output logic [N*AW-1:0]      xcorr_re_o,
  output logic [N*AW-1:0]      xcorr_im_o
);
  localparam int FW = $clog2(N);

  logic [FW-1:0]       fill_q;
  logic                full, act, first, last;
  logic [BLK_BITS-1:0] idx_q;

  logic signed [XW-1:0] tap_re [N];
  logic signed [XW-1:0] tap_im [N];
  logic                 c_ref_re, c_ref_im;
  pilot_t               pil;

  assign full  = (fill_q == FW'(N-1));
  assign act   = chip_valid_i && full;
  assign first = (idx_q == '0);
  assign last  = act && (idx_q == BLK_BITS'(BLK_LEN-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q       <= '0;
      idx_q        <= '0;
      corr_valid_o <= 1'b0;
    end else begin
      if (chip_valid_i && !full) fill_q <= fill_q + 1'b1;
      if (act) idx_q <= idx_q + 1'b1;
      corr_valid_o <= last;
    end
  end

  tce_delay #(.N(N), .XW(XW)) u_delay (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (chip_valid_i),
    .x_re_i   (chip_re_i),
    .x_im_i   (chip_im_i),
    .c_re_i   (code_re_i),
    .c_im_i   (code_im_i),
    .tap_re_o (tap_re),
    .tap_im_o (tap_im),
    .c_re_o   (c_ref_re),
    .c_im_o   (c_ref_im)
  );

  assign pil = pilot_half(c_ref_re, c_ref_im);

  // reference x[i] is the oldest tap; x[i+k] sits k taps newer
  for (genvar k = 0; k < N; k++) begin : g_lag
    logic signed [AW-1:0] ac_re, ac_im, xc_re, xc_im;

    tce_lane #(.XW(XW), .AW(AW)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .act_i     (act),
      .first_i   (first),
      .lead_re_i (tap_re[N-1-k]),
      .lead_im_i (tap_im[N-1-k]),
      .ref_re_i  (tap_re[N-1]),
      .ref_im_i  (tap_im[N-1]),
      .pil_i     (pil),
      .ac_re_o   (ac_re),
      .ac_im_o   (ac_im),
      .xc_re_o   (xc_re),
      .xc_im_o   (xc_im)
    );

    tce_smooth #(.AW(AW)) u_sm_ar (
      .clk_i(clk_i), .rst_ni(rst_ni), .push_i(last), .sum_i(ac_re),
      .avg_o(auto_re_o[k*AW +: AW]));
    tce_smooth #(.AW(AW)) u_sm_ai (
      .clk_i(clk_i), .rst_ni(rst_ni), .push_i(last), .sum_i(ac_im),
      .avg_o(auto_im_o[k*AW +: AW]));
    tce_smooth #(.AW(AW)) u_sm_xr (
      .clk_i(clk_i), .rst_ni(rst_ni), .push_i(last), .sum_i(xc_re),
      .avg_o(xcorr_re_o[k*AW +: AW]));
    tce_smooth #(.AW(AW)) u_sm_xi (
      .clk_i(clk_i), .rst_ni(rst_ni), .push_i(last), .sum_i(xc_im),
      .avg_o(xcorr_im_o[k*AW +: AW]));
  end
endmodule

// File: rtl/tce_checker.sv
module tce_checker
  import tce_pkg::*;
#(
  parameter  int N  = 7,
  parameter  int XW = 8,
  localparam int AW = 2*XW + 1 + BLK_BITS
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            chip_valid_i,
  input logic            corr_valid_o,
  input logic [N*AW-1:0] auto_re_o,
  input logic [N*AW-1:0] auto_im_o,
  input logic [N*AW-1:0] xcorr_re_o,
  input logic [N*AW-1:0] xcorr_im_o
);
  logic [9:0] chips_q;

  // accepted chips since the last strobe, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chips_q <= '0;
    else if (corr_valid_o) chips_q <= chip_valid_i ? 10'd1 : 10'd0;
    else if (chip_valid_i && chips_q != '1) chips_q <= chips_q + 1'b1;
  end

  assert_single_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_valid_o |=> !corr_valid_o);

  assert_block_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_valid_o |-> chips_q >= 10'd256);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !corr_valid_o |-> ($stable(auto_re_o) && $stable(auto_im_o) &&
                       $stable(xcorr_re_o) && $stable(xcorr_im_o)));

  assert_chip_before_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_valid_o |-> $past(chip_valid_i));

  assert_lag0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_valid_o |-> (!auto_re_o[AW-1] && auto_im_o[AW-1:0] == '0));
endmodule

bind toeplitz_corr_est tce_checker #(.N(N), .XW(XW)) u_tce_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .chip_valid_i (chip_valid_i),
  .corr_valid_o (corr_valid_o),
  .auto_re_o    (auto_re_o),
  .auto_im_o    (auto_im_o),
  .xcorr_re_o   (xcorr_re_o),
  .xcorr_im_o   (xcorr_im_o)
);

// File: tb/toeplitz_corr_est_test.sv
module toeplitz_corr_est_test;
  localparam int N    = 7;
  localparam int XW   = 8;
  localparam int AW   = 2*XW + 9;
  localparam int NB   = 6;
  localparam int OFFB = NB*256 + N - 1 + 100;
  localparam int TOT  = OFFB + 256 + N - 1;

  // per-block stimulus: pattern kind, idle-cycle spacing (0 = none), strobe count expected after it
  localparam int PAT_KIND [NB] = '{1, 0, 2, 1, 3, 1};
  localparam int PAT_GAP  [NB] = '{0, 0, 0, 7, 0, 3};
  localparam int PAT_CNT  [NB] = '{262, 518, 774, 1030, 1286, 1542};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_valid = 1'b0;
  logic signed [XW-1:0] chip_re = '0, chip_im = '0;
  logic code_re = 1'b0, code_im = 1'b0;
  logic corr_valid;
  logic [N*AW-1:0] auto_re, auto_im, xcorr_re, xcorr_im;

  always #4 clk = ~clk;

  toeplitz_corr_est #(.N(N), .XW(XW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .chip_valid_i(chip_valid),
    .chip_re_i(chip_re), .chip_im_i(chip_im),
    .code_re_i(code_re), .code_im_i(code_im),
    .corr_valid_o(corr_valid),
    .auto_re_o(auto_re), .auto_im_o(auto_im),
    .xcorr_re_o(xcorr_re), .xcorr_im_o(xcorr_im));

  int n_chk = 0, n_fail = 0;
  int xr [TOT], xi [TOT];
  bit cr [TOT], ci [TOT];
  longint s_ar [NB+1][N], s_ai [NB+1][N], s_xr [NB+1][N], s_xi [NB+1][N];
  longint e_ar [NB+1][N], e_ai [NB+1][N], e_xr [NB+1][N], e_xi [NB+1][N];
  int acc_cnt;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) acc_cnt <= 0;
    else if (chip_valid) acc_cnt <= acc_cnt + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  function automatic longint fld(input logic [N*AW-1:0] v, input int k);
    logic signed [AW-1:0] t;
    t = v[k*AW +: AW];
    return longint'(t);
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  function automatic void build();
    int unsigned st = 32'h1234_5678;
    for (int g = 0; g < TOT; g++) begin
      int kind;
      logic signed [7:0] t8a, t8b;
      kind = (g < OFFB) ? PAT_KIND[(g/256 < NB) ? g/256 : NB-1] : 1;
      st = st * 32'd1103515245 + 32'd12345;
      case (kind)
        0: begin xr[g] = -128; xi[g] = -128; cr[g] = st[3]; ci[g] = st[7]; end
        2: begin
             xr[g] = (g % 2 == 1) ? 127 : -128;
             xi[g] = (g % 3 == 0) ? -128 : 127;
             cr[g] = g[0]; ci[g] = g[1];
           end
        3: begin xr[g] = 0; xi[g] = 0; cr[g] = st[3]; ci[g] = st[7]; end
        default: begin
             t8a = st[23:16]; t8b = st[15:8];
             xr[g] = t8a; xi[g] = t8b; cr[g] = st[3]; ci[g] = st[7];
           end
      endcase
    end
    for (int e = 0; e <= NB; e++) begin
      int base;
      base = (e < NB) ? e*256 : OFFB;
      for (int k = 0; k < N; k++) begin
        s_ar[e][k] = 0; s_ai[e][k] = 0; s_xr[e][k] = 0; s_xi[e][k] = 0;
        for (int i = 0; i < 256; i++) begin
          longint a, b, c, d, dr, di;
          int g;
          g = base + i;
          a = xr[g+k]; b = xi[g+k]; c = xr[g]; d = xi[g];
          dr = (cr[g] ? -1 : 1) - (ci[g] ? -1 : 1);
          di = (cr[g] ? -1 : 1) + (ci[g] ? -1 : 1);
          s_ar[e][k] += a*c + b*d;
          s_ai[e][k] += b*c - a*d;
          s_xr[e][k] += a*dr - b*di;
          s_xi[e][k] += a*di + b*dr;
        end
      end
    end
    for (int e = 0; e <= NB; e++) begin
      for (int k = 0; k < N; k++) begin
        longint sa, sb, sc, sd;
        sa = 0; sb = 0; sc = 0; sd = 0;
        for (int j = e - 3; j <= e; j++) begin
          if (j >= 0 && (e < NB || j == e)) begin
            sa += s_ar[j][k]; sb += s_ai[j][k]; sc += s_xr[j][k]; sd += s_xi[j][k];
          end
        end
        e_ar[e][k] = sa >>> 2; e_ai[e][k] = sb >>> 2;
        e_xr[e][k] = sc >>> 2; e_xi[e][k] = sd >>> 2;
      end
    end
  endfunction

  task automatic drive_range(input int from, input int upto, input bit gaps);
    for (int g = from; g < upto; g++) begin
      int gp;
      gp = (gaps && g/256 < NB) ? PAT_GAP[g/256] : 0;
      @(negedge clk);
      chip_valid = 1'b1;
      chip_re = XW'(xr[g]); chip_im = XW'(xi[g]);
      code_re = cr[g]; code_im = ci[g];
      if (gp > 0 && g % gp == 0) begin
        @(negedge clk);
        chip_valid = 1'b0;
        chip_re = -8'sd77; chip_im = 8'sd55; code_re = 1'b1; code_im = 1'b0;
      end
    end
    @(negedge clk);
    chip_valid = 1'b0;
  endtask

  task automatic cmp_all(input int e, input string tag);
    for (int k = 0; k < N; k++) begin
      chk(fld(auto_re, k) == e_ar[e][k], tag, $sformatf("blk %0d lag %0d auto_re", e, k),
          fld(auto_re, k), e_ar[e][k]);
      chk(fld(auto_im, k) == e_ai[e][k], tag, $sformatf("blk %0d lag %0d auto_im", e, k),
          fld(auto_im, k), e_ai[e][k]);
      chk(fld(xcorr_re, k) == e_xr[e][k], tag, $sformatf("blk %0d lag %0d xcorr_re", e, k),
          fld(xcorr_re, k), e_xr[e][k]);
      chk(fld(xcorr_im, k) == e_xi[e][k], tag, $sformatf("blk %0d lag %0d xcorr_im", e, k),
          fld(xcorr_im, k), e_xi[e][k]);
    end
  endtask

  task automatic check_stream();
    for (int b = 0; b < NB; b++) begin
      string tag;
      do @(negedge clk); while (!corr_valid);
      // R5: strobe right after the edge accepting chip 256*(b+1)+N-1
      chk(acc_cnt == PAT_CNT[b], "R5", $sformatf("blk %0d accepted chips at strobe", b),
          acc_cnt, PAT_CNT[b]);
      if (PAT_GAP[b] != 0) tag = "R7 R2 R3 R4";
      else if (b == 0) tag = "R2 R3 R9";
      else tag = "R4 R2 R3";
      cmp_all(b, tag);
      // R8: lag 0 is real and non-negative
      chk(fld(auto_im, 0) == 0 && fld(auto_re, 0) >= 0, "R8", "lag0 auto",
          fld(auto_im, 0), 0);
      @(negedge clk);
      chk(corr_valid == 1'b0, "R5", "strobe second cycle", corr_valid, 0);
      repeat (100) @(negedge clk);
      // R6: values held mid-block
      cmp_all(b, "R6");
    end
  endtask

  initial begin
    build();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(corr_valid == 1'b0, "R1", "valid in reset", corr_valid, 0);
    chk(auto_re == '0 && auto_im == '0 && xcorr_re == '0 && xcorr_im == '0,
        "R1", "buses in reset", longint'(auto_re[AW-1:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(corr_valid == 1'b0 && auto_re == '0, "R1", "after release", corr_valid, 0);

    fork
      drive_range(0, OFFB, 1'b1);
      check_stream();
    join

    // R10: reset mid-block
    drive_range(OFFB - 60, OFFB, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(corr_valid == 1'b0 && auto_re == '0 && auto_im == '0 &&
        xcorr_re == '0 && xcorr_im == '0, "R10 R1", "buses after mid-block reset",
        longint'(xcorr_re[AW-1:0]), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int g = OFFB; g < TOT; g++) begin
      @(negedge clk);
      chip_valid = 1'b1;
      chip_re = XW'(xr[g]); chip_im = XW'(xi[g]);
      code_re = cr[g]; code_im = ci[g];
      if (g < TOT - 1) begin
        #1;
        if (corr_valid) chk(1'b0, "R5", "early strobe after reset", 1, 0);
      end
    end
    @(negedge clk);
    chip_valid = 1'b0;
    chk(corr_valid == 1'b1, "R5 R10", "strobe after refill", corr_valid, 1);
    chk(acc_cnt == 256 + N - 1, "R10", "chips since reset", acc_cnt, 256 + N - 1);
    cmp_all(NB, "R10");
    @(negedge clk);
    chk(corr_valid == 1'b0, "R5", "strobe width after reset", corr_valid, 0);
    cmp_all(NB, "R6 R7");

    summary();
    $finish;
  end
endmodule